// File: doc/BRIEF.md
# Phase-Order Sector Detector with Zero-Sequence Pick

This block sits in front of a carrier-based space-vector modulator. It receives three normalized, signed phase references for one sample. From their relative order it finds which of the six hexagon sectors the reference vector lies in. It also passes on the one phase reference that serves as the zero-sequence term for that sector, and the modulator uses that term to build its modified carrier.

The sector comes only from three pairwise signed comparisons and two exclusive-OR flags. The block does no angle computation and no coordinate transform. Let fa be 1 when ref_a ≥ ref_b, fb be 1 when ref_b ≥ ref_c, and fc be 1 when ref_c ≥ ref_a. Let x1 = fa XOR fb and x2 = fb XOR fc. The zero-sequence phase is b when x1=0 and x2=1, a when x1=1 and x2=1, and c in every other case. The results are registered, so they appear one cycle after a valid sample.

Top module: `ssel_top`

## Requirements
- R1: For a valid sample with three distinct references, the sector is decoded from the ordering as follows: c<b<a gives 1, c<a<b gives 2, a<c<b gives 3, a<b<c gives 4, b<a<c gives 5 and b<c<a gives 6. The sector is encoded as a 3-bit unsigned number.
- R2: The zero-sequence output equals ref_b in sectors 1 and 4, ref_a in sectors 2 and 5, and ref_c in sectors 3 and 6. In all cases it is the value the sample carried.
- R3: All comparisons treat the references as two's complement numbers at the input width, with no scaling. The most negative code is below every other value.
- R4: Equal references count as "greater or equal" in every flag. For example, a=b>c gives flags 110 (sector 1, output ref_b), and a=c>b gives flags 101 (sector 5, output ref_a).
- R5: When all three references are equal, the flags read 111. The block reports sector 1 and outputs the common reference value.
- R6: Sector and zero-sequence results appear exactly one clock after the valid sample. out_valid is in_valid delayed by one clock, and valid samples may arrive on back-to-back cycles.
- R7: A cycle with in_valid low changes neither sector nor zero_seq, whatever the references carry.
- R8: While reset is asserted and after it, until the first valid sample, out_valid is 0, sector is 1 and zero_seq is 0.
- R9: The sector output is always in the range 1 to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe for the three references |
| ref_a | input | W | Phase a reference, signed |
| ref_b | input | W | Phase b reference, signed |
| ref_c | input | W | Phase c reference, signed |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| sector | output | 3 | Sector number 1..6 |
| zero_seq | output | W | Selected zero-sequence reference, signed |

## Verification
One sample per ordering of three distinct values is applied, using a different value for the selected phase each time. This separates the six sector codes from one another and shows which phase feeds the output. Samples that straddle zero or use the full-scale extremes separate a signed comparison from an unsigned one. Pairwise ties and a fully equal sample pin down the "greater or equal" edge and the 111 fallback. An idle cycle with changed references shows that the outputs hold. Streaming the table back to back confirms the one-cycle latency.

// File: rtl/ssel_pkg.sv
package ssel_pkg;

  typedef enum logic [1:0] {
    PICK_A = 2'd0,
    PICK_B = 2'd1,
    PICK_C = 2'd2
  } pick_e;

  // flags are {a>=b, b>=c, c>=a}, msb first
  function automatic logic [2:0] sector_of(input logic [2:0] flags);
    logic [2:0] s;
    case (flags)
      3'b110:  s = 3'd1;
      3'b010:  s = 3'd2;
      3'b011:  s = 3'd3;
      3'b001:  s = 3'd4;
      3'b101:  s = 3'd5;
      3'b100:  s = 3'd6;
      default: s = 3'd1; // 111 (all equal) and unreachable 000
    endcase
    return s;
  endfunction

  function automatic pick_e pick_of(input logic x1, input logic x2);
    pick_e p;
    if (!x1 && x2)      p = PICK_B;
    else if (x1 && x2)  p = PICK_A;
    else                p = PICK_C;
    return p;
  endfunction

endpackage

// File: rtl/ssel_compare.sv
module ssel_compare #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] refs [3],
  output logic        [2:0]   ge    // ge[i] = refs[i] >= refs[(i+1)%3]
);
  localparam int NPH = 3;

  for (genvar i = 0; i < NPH; i++) begin : g_pair
    localparam int NXT = (i + 1) % NPH;
    assign ge[i] = (refs[i] >= refs[NXT]);
  end
endmodule

// File: rtl/ssel_decode.sv
module ssel_decode
  import ssel_pkg::*;
(
  input  logic [2:0] flags,   // {a>=b, b>=c, c>=a}
  output logic [2:0] sector,
  output logic       x1,
  output logic       x2,
  output pick_e      pick
);
  assign x1     = flags[2] ^ flags[1];
  assign x2     = flags[1] ^ flags[0];
  assign sector = sector_of(flags);
  assign pick   = pick_of(x1, x2);
endmodule

// File: rtl/ssel_mux.sv
module ssel_mux
  import ssel_pkg::*;
#(
  parameter int W = 16
) (
  input  pick_e               pick,
  input  logic signed [W-1:0] refs [3],
  output logic signed [W-1:0] value
);
  always_comb begin
    case (pick)
      PICK_A:  value = refs[0];
      PICK_B:  value = refs[1];
      default: value = refs[2];
    endcase
  end
endmodule

// File: rtl/ssel_top.sv
module ssel_top
  import ssel_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic signed [W-1:0] ref_a,
  input  logic signed [W-1:0] ref_b,
  input  logic signed [W-1:0] ref_c,
  output logic                out_valid,
  output logic [2:0]          sector,
  output logic signed [W-1:0] zero_seq
);
  localparam logic [2:0] SECTOR_RST = 3'd1;

  logic signed [W-1:0] refs [3];
  logic [2:0]          ge;
  logic [2:0]          cmp_flags;   // {a>=b, b>=c, c>=a}
  logic [2:0]          dec_sector;
  logic                dec_x1;
  logic                dec_x2;
  pick_e               dec_pick;
  logic signed [W-1:0] mux_value;

  assign refs[0] = ref_a;
  assign refs[1] = ref_b;
  assign refs[2] = ref_c;

  ssel_compare #(.W(W)) u_cmp (
    .refs (refs),
    .ge   (ge)
  );

  assign cmp_flags = {ge[0], ge[1], ge[2]};

  ssel_decode u_dec (
    .flags  (cmp_flags),
    .sector (dec_sector),
    .x1     (dec_x1),
    .x2     (dec_x2),
    .pick   (dec_pick)
  );

  ssel_mux #(.W(W)) u_mux (
    .pick  (dec_pick),
    .refs  (refs),
    .value (mux_value)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sector    <= SECTOR_RST;
      zero_seq  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sector   <= dec_sector;
        zero_seq <= mux_value;
      end
    end
  end
endmodule

// File: rtl/ssel_chk.sv
module ssel_chk #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic signed [W-1:0] ref_a,
  input logic signed [W-1:0] ref_b,
  input logic signed [W-1:0] ref_c,
  input logic [2:0]          flags,
  input logic                out_valid,
  input logic [2:0]          sector,
  input logic signed [W-1:0] zero_seq
);
  // R6
  p_valid_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(in_valid));

  // R9
  p_sector_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sector >= 3'd1 && sector <= 3'd6);

  // R7
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(in_valid)) |-> ($stable(sector) && $stable(zero_seq)));

  // R2
  p_zs_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (sector == 3'd1 || sector == 3'd4)) |-> zero_seq == $past(ref_b));
  p_zs_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (sector == 3'd2 || sector == 3'd5)) |-> zero_seq == $past(ref_a));
  p_zs_c_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (sector == 3'd3 || sector == 3'd6)) |-> zero_seq == $past(ref_c));

  // R1: sector 4 only for a<=b<=c order
  p_sector4_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sector == 3'd4) |-> ($past(ref_a) < $past(ref_b) && $past(ref_b) < $past(ref_c)));

  // R3: three cyclic flags can never all be zero on signed data
  p_flags_consistent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> flags != 3'b000);
endmodule

bind ssel_top ssel_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .ref_a     (ref_a),
  .ref_b     (ref_b),
  .ref_c     (ref_c),
  .flags     (cmp_flags),
  .out_valid (out_valid),
  .sector    (sector),
  .zero_seq  (zero_seq)
);

// File: tb/ssel_top_tb.sv
module ssel_top_tb;
  localparam int W  = 16;
  localparam int NV = 14;

  // stimulus a, b, c and expected sector / zero-sequence value
  localparam logic signed [W-1:0] TA [NV] = '{ 16'sd100,  16'sd0,    -16'sd100, -16'sd100, 16'sd0,    16'sd100,
                                               16'sd30000, -16'sd32768, -16'sd1, -16'sd32768, 16'sd5, 16'sd4, 16'sd2, -16'sd1 };
  localparam logic signed [W-1:0] TB [NV] = '{ 16'sd11,   16'sd100,  16'sd100,  16'sd22,   -16'sd100, -16'sd100,
                                               -16'sd5,  16'sd32767, -16'sd2,  16'sd1,  16'sd5, 16'sd4, -16'sd7, 16'sd0 };
  localparam logic signed [W-1:0] TC [NV] = '{ -16'sd100, -16'sd100, 16'sd33,   16'sd100,  16'sd100,  16'sd44,
                                               -16'sd32768, 16'sd7,  -16'sd3,  16'sd2,  16'sd5, -16'sd9, 16'sd2, 16'sd1 };
  localparam logic [2:0]          ES [NV] = '{ 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6,
                                               3'd1, 3'd3, 3'd1, 3'd4, 3'd1, 3'd1, 3'd5, 3'd4 };
  localparam logic signed [W-1:0] EZ [NV] = '{ 16'sd11, 16'sd0, 16'sd33, 16'sd22, 16'sd0, 16'sd44,
                                               -16'sd5, 16'sd7, -16'sd2, 16'sd1, 16'sd5, 16'sd4, 16'sd2, 16'sd0 };
  localparam string RQ [NV] = '{ "R1", "R1", "R1", "R1", "R1", "R1",
                                 "R3", "R3", "R3", "R3", "R5", "R4", "R4", "R3" };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [W-1:0] ref_a = '0, ref_b = '0, ref_c = '0;
  logic out_valid;
  logic [2:0] sector;
  logic signed [W-1:0] zero_seq;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ssel_top #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
    .out_valid(out_valid), .sector(sector), .zero_seq(zero_seq)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input bit v, input logic signed [W-1:0] a,
                       input logic signed [W-1:0] b, input logic signed [W-1:0] c);
    in_valid = v; ref_a = a; ref_b = b; ref_c = c;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [2:0]          hold_s;
    logic signed [W-1:0] hold_z;
    // R8: reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8", "out_valid in reset", int'(out_valid), 0);
    check(sector == 3'd1, "R8", "sector in reset", int'(sector), 1);
    check(zero_seq == 0, "R8", "zero_seq in reset", int'(zero_seq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && sector == 3'd1 && zero_seq == 0, "R8",
          "idle after reset", int'(sector), 1);

    // table walked back to back; result of vector i seen one cycle later (R6)
    drive(1'b1, TA[0], TB[0], TC[0]);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      check(out_valid == 1'b1, "R6", "out_valid after sample", int'(out_valid), 1);
      check(sector == ES[i], RQ[i], $sformatf("sector vec %0d", i), int'(sector), int'(ES[i]));
      check(zero_seq == EZ[i], (RQ[i] == "R1") ? "R2" : RQ[i],
            $sformatf("zero_seq vec %0d", i), int'(zero_seq), int'(EZ[i]));
      check(sector >= 3'd1 && sector <= 3'd6, "R9", "sector range", int'(sector), 1);
      if (i + 1 < NV) drive(1'b1, TA[i+1], TB[i+1], TC[i+1]);
    end

    // R7: idle cycles with new references leave outputs unchanged
    hold_s = sector;
    hold_z = zero_seq;
    drive(1'b0, 16'sd0, 16'sd500, -16'sd500);
    @(negedge clk);
    check(out_valid == 1'b0, "R6", "out_valid drops", int'(out_valid), 0);
    drive(1'b0, -16'sd300, 16'sd900, 16'sd12);
    @(negedge clk);
    check(sector == hold_s, "R7", "sector held", int'(sector), int'(hold_s));
    check(zero_seq == hold_z, "R7", "zero_seq held", int'(zero_seq), int'(hold_z));

    // R4: a=c above b -> flags 101, sector 5, phase a
    drive(1'b1, 16'sd60, -16'sd60, 16'sd60);
    @(negedge clk);
    drive(1'b0, 16'sd0, 16'sd0, 16'sd0);
    check(sector == 3'd5, "R4", "tie a=c sector", int'(sector), 5);
    check(zero_seq == 16'sd60, "R4", "tie a=c zero_seq", int'(zero_seq), 60);

    // R2: sector 6 with distinct phase c value
    drive(1'b1, 16'sd9000, -16'sd9000, -16'sd1234);
    @(negedge clk);
    drive(1'b0, 16'sd0, 16'sd0, 16'sd0);
    check(sector == 3'd6, "R1", "sector 6", int'(sector), 6);
    check(zero_seq == -16'sd1234, "R2", "sector 6 picks c", int'(zero_seq), -1234);

    // R8: reset again restores initial outputs
    rst_n = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && sector == 3'd1 && zero_seq == 0, "R8",
          "re-reset state", int'(zero_seq), 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule